// File: doc/BRIEF.md
# Flash Read-Buffer Bus Interface

This block connects a system bus slave port to a flash array that needs several clock cycles per access. It keeps a few 128-bit line buffers. A read that finds its line in a valid buffer is answered in the next cycle, and the array is not touched. A read that misses starts an array access. When the access ends, the requested 32-bit word goes to the bus, and in the same clock edge the whole line is written into the buffer that was filled longest ago.

Every transfer is first checked against a read-permission mask and a write-permission mask. Each mask has one bit per bus master. A refused transfer gets a bus error and never reaches the array. The access length is a programmable wait-state count. Reads can add a second count, chosen by whether the bus marks the read as single or as a burst, so that a slower memory can be imitated. With address pipelining on, the array request starts in the same cycle the bus presents the transfer. An array request that has been issued always runs to completion. An array error becomes a bus error and throws away the buffer that was being filled.

Top module: `flash_rdbuf_biu`

## Requirements
- R1: After reset, bus_ready, bus_error and arr_req are low and every line buffer is empty, so the first read of any line is a miss.
- R2: Bit m of cfg_rd_allow permits reads from master m, and bit m of cfg_wr_allow permits its writes. A refused transfer gets bus_error one cycle after acceptance and issues no array request.
- R3: A permitted read whose line (address bits 31:4) is held in a valid buffer gets bus_ready one cycle after acceptance, with the buffered word and no array request.
- R4: A miss or a write issues exactly one array request. The response comes W+1 cycles after the accepting edge with pipelining on, and W+2 cycles after it with pipelining off. W is cfg_wait for writes, cfg_wait+cfg_xws_single for reads with bus_burst low, and cfg_wait+cfg_xws_burst for reads with bus_burst high.
- R5: With cfg_pipe high, arr_req is asserted in the same cycle the transfer is presented. With cfg_pipe low, it is asserted one cycle later.
- R6: A successful miss returns word k of the line, where k is address bits 3:2 and word k occupies bits 32k+31:32k. The line is stored in the same edge, so later reads of any word of that line hit.
- R7: A fill goes to the lowest-numbered empty buffer. If no buffer is empty, it goes to the buffer filled longest ago. A hit does not change this order.
- R8: Once an array request has been issued, the access completes and its response is delivered even if the bus request is withdrawn.
- R9: An array error on a read miss gives bus_error instead of bus_ready, and leaves empty the buffer chosen for the fill.
- R10: A permitted write gives bus_ready, or bus_error if the array signals an error, and it empties any buffer holding the written line.
- R11: Each accepted transfer gets exactly one one-cycle pulse of bus_ready or bus_error, never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Read request, held until the response |
| bus_wr | input | 1 | Write request, held until the response |
| bus_burst | input | 1 | Marks a read as a burst for extra wait-state selection |
| bus_mid | input | 3 | Requesting master number |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Successful completion pulse |
| bus_error | output | 1 | Error completion pulse |
| cfg_rd_allow | input | 8 | Read permission, one bit per master |
| cfg_wr_allow | input | 8 | Write permission, one bit per master |
| cfg_wait | input | 4 | Base array wait states |
| cfg_xws_single | input | 4 | Extra wait states for single reads |
| cfg_xws_burst | input | 4 | Extra wait states for burst reads |
| cfg_pipe | input | 1 | Issue the array request in the presentation cycle |
| arr_req | output | 1 | Array request strobe |
| arr_we | output | 1 | Array request is a write |
| arr_addr | output | 32 | Array address |
| arr_wdata | output | 32 | Array write data |
| arr_rdata | input | 128 | Array line data, sampled when the access ends |
| arr_err | input | 1 | Array error flag, sampled when the access ends |

## Verification
The bench drives each transfer at a falling edge and counts falling edges until a response appears. The expected count is 1 for a hit or a refusal, W+2 for a miss or write with pipelining on, and W+3 with pipelining off. arr_req is sampled just after the inputs settle in the presentation cycle, which shows whether the request was issued early. A bench model of the buffers, keyed by fill order, predicts hits. The number of array requests seen during each transfer is compared with the one request expected for a miss or write and zero otherwise.

// File: rtl/fbiu_pkg.sv
package fbiu_pkg;
  localparam int unsigned FB_ADDR_W = 32;
  localparam int unsigned FB_DATA_W = 32;
  localparam int unsigned FB_LINE_W = 128;
  localparam int unsigned FB_WS_W   = 4;
  localparam int unsigned FB_WORDS  = FB_LINE_W / FB_DATA_W;
  localparam int unsigned FB_OFF_W  = $clog2(FB_LINE_W / 8);
  localparam int unsigned FB_WSEL_W = $clog2(FB_WORDS);
  localparam int unsigned FB_TAG_W  = FB_ADDR_W - FB_OFF_W;

  typedef logic [FB_ADDR_W-1:0] addr_t;
  typedef logic [FB_TAG_W-1:0]  tag_t;
  typedef logic [FB_LINE_W-1:0] line_t;
  typedef logic [FB_DATA_W-1:0] word_t;
  typedef logic [FB_WS_W:0]     wcnt_t;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} acc_st_e;

  function automatic tag_t line_tag(addr_t a);
    return a[FB_ADDR_W-1:FB_OFF_W];
  endfunction

  function automatic word_t pick_word(line_t l, addr_t a);
    word_t w;
    w = '0;
    for (int k = 0; k < FB_WORDS; k++)
      if (a[FB_OFF_W-1 -: FB_WSEL_W] == FB_WSEL_W'(k)) w = l[k*FB_DATA_W +: FB_DATA_W];
    return w;
  endfunction

  // Wait states of one array access: base plus a read-only extra chosen by burst.
  function automatic wcnt_t access_wait(logic is_wr, logic burst, logic [FB_WS_W-1:0] ws,
                                        logic [FB_WS_W-1:0] xs, logic [FB_WS_W-1:0] xb);
    logic [FB_WS_W-1:0] extra;
    extra = is_wr ? '0 : (burst ? xb : xs);
    return {1'b0, ws} + {1'b0, extra};
  endfunction
endpackage

// File: rtl/fbiu_perm_check.sv
module fbiu_perm_check #(
  parameter int unsigned MID_W = 3,
  localparam int unsigned NMASTER = 1 << MID_W
) (
  input  logic [MID_W-1:0]   mid,
  input  logic [NMASTER-1:0] rd_allow,
  input  logic [NMASTER-1:0] wr_allow,
  output logic               rd_ok,
  output logic               wr_ok
);
  assign rd_ok = rd_allow[mid];
  assign wr_ok = wr_allow[mid];
endmodule

// File: rtl/fbiu_line_buf.sv
module fbiu_line_buf import fbiu_pkg::*; #(
  parameter int unsigned NBUF = 4,
  localparam int unsigned AGE_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  tag_t  lk_tag,
  output logic  lk_hit,
  output line_t lk_line,
  input  logic  upd_en,
  input  logic  upd_err,
  input  tag_t  upd_tag,
  input  line_t upd_line,
  input  logic  inv_en,
  input  tag_t  inv_tag
);
  tag_t             tags  [NBUF];
  line_t            lines [NBUF];
  logic [AGE_W-1:0] age   [NBUF];
  logic [NBUF-1:0]  valid;
  logic [NBUF-1:0]  hit_vec;
  logic [NBUF-1:0]  zero_age_vec;
  logic [AGE_W-1:0] victim;

  always_comb begin
    lk_line = '0;
    for (int i = 0; i < NBUF; i++) begin
      hit_vec[i]      = valid[i] && (tags[i] == lk_tag);
      zero_age_vec[i] = (age[i] == '0);
      if (hit_vec[i]) lk_line = lines[i];
    end
    lk_hit = |hit_vec;
  end

  // Oldest fill is the default victim; the lowest empty buffer overrides it.
  always_comb begin
    victim = '0;
    for (int i = 0; i < NBUF; i++)
      if (age[i] == AGE_W'(NBUF - 1)) victim = AGE_W'(i);
    for (int i = NBUF - 1; i >= 0; i--)
      if (!valid[i]) victim = AGE_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      for (int i = 0; i < NBUF; i++) age[i] <= AGE_W'(i);
    end else begin
      for (int i = 0; i < NBUF; i++) begin
        if (upd_en && victim == AGE_W'(i)) begin
          valid[i] <= !upd_err;
          if (!upd_err) begin
            tags[i]  <= upd_tag;
            lines[i] <= upd_line;
          end
        end else if (inv_en && valid[i] && tags[i] == inv_tag) begin
          valid[i] <= 1'b0;
        end
        if (upd_en && !upd_err) begin
          if (victim == AGE_W'(i))       age[i] <= '0;
          else if (age[i] < age[victim]) age[i] <= age[i] + 1'b1;
        end
      end
    end
  end

  // R6
  hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
  // R7
  age_order_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot(zero_age_vec));
endmodule

// File: rtl/fbiu_access_ctl.sv
module fbiu_access_ctl import fbiu_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_rd,
  input  logic               req_wr,
  input  logic               req_burst,
  input  addr_t              req_addr,
  input  word_t              req_wdata,
  input  logic               rd_ok,
  input  logic               wr_ok,
  input  logic               hit,
  input  line_t              hit_line,
  input  logic [FB_WS_W-1:0] cfg_wait,
  input  logic [FB_WS_W-1:0] cfg_xs,
  input  logic [FB_WS_W-1:0] cfg_xb,
  input  logic               cfg_pipe,
  output logic               arr_req,
  output logic               arr_we,
  output addr_t              arr_addr,
  output word_t              arr_wdata,
  input  line_t              arr_rdata,
  input  logic               arr_err,
  output logic               resp_rdy,
  output logic               resp_err,
  output word_t              resp_data,
  output logic               upd_en,
  output logic               upd_err,
  output tag_t               upd_tag,
  output logic               inv_en,
  output tag_t               inv_tag
);
  acc_st_e state;
  wcnt_t   wcnt;
  addr_t   hold_addr;
  word_t   hold_wdata;
  logic    hold_we;
  logic    accept, is_wr, deny, hit_take, go_arr, done;
  word_t   hit_word;

  assign is_wr    = req_wr && !req_rd;
  assign accept   = (state == ST_IDLE) && (req_rd || req_wr) && !resp_rdy && !resp_err;
  assign deny     = accept && (is_wr ? !wr_ok : !rd_ok);
  assign hit_take = accept && !deny && !is_wr && hit;
  assign go_arr   = accept && !deny && !hit_take;
  assign done     = (state == ST_WAIT) && (wcnt == '0);
  assign hit_word = pick_word(hit_line, req_addr);

  assign arr_req   = (go_arr && cfg_pipe) || (state == ST_ISSUE);
  assign arr_addr  = (state == ST_IDLE) ? req_addr  : hold_addr;
  assign arr_we    = (state == ST_IDLE) ? is_wr     : hold_we;
  assign arr_wdata = (state == ST_IDLE) ? req_wdata : hold_wdata;

  assign upd_en  = done && !hold_we;
  assign upd_err = arr_err;
  assign upd_tag = line_tag(hold_addr);
  assign inv_en  = go_arr && is_wr;
  assign inv_tag = line_tag(req_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      wcnt       <= '0;
      hold_addr  <= '0;
      hold_wdata <= '0;
      hold_we    <= 1'b0;
      resp_rdy   <= 1'b0;
      resp_err   <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_rdy <= 1'b0;
      resp_err <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (deny) resp_err <= 1'b1;
          if (hit_take) begin
            resp_rdy  <= 1'b1;
            resp_data <= hit_word;
          end
          if (go_arr) begin
            hold_addr  <= req_addr;
            hold_wdata <= req_wdata;
            hold_we    <= is_wr;
            wcnt       <= access_wait(is_wr, req_burst, cfg_wait, cfg_xs, cfg_xb);
            state      <= cfg_pipe ? ST_WAIT : ST_ISSUE;
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (wcnt == '0) begin
            state    <= ST_IDLE;
            resp_rdy <= !arr_err;
            resp_err <= arr_err;
            if (!hold_we && !arr_err) resp_data <= pick_word(arr_rdata, hold_addr);
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(resp_rdy && resp_err));
  // R2
  perm_deny_chk: assert property (@(posedge clk) disable iff (!rst_n) deny |=> (resp_err && !resp_rdy));
  // R3
  hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_take |=> (resp_rdy && resp_data == $past(hit_word)));
  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && wcnt != '0) |=> (state == ST_WAIT && $stable(hold_addr)));
endmodule

// File: rtl/flash_rdbuf_biu.sv
module flash_rdbuf_biu import fbiu_pkg::*; #(
  parameter int unsigned MID_W = 3,
  parameter int unsigned NBUF  = 4,
  localparam int unsigned NMASTER = 1 << MID_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic                 bus_burst,
  input  logic [MID_W-1:0]     bus_mid,
  input  logic [FB_ADDR_W-1:0] bus_addr,
  input  logic [FB_DATA_W-1:0] bus_wdata,
  output logic [FB_DATA_W-1:0] bus_rdata,
  output logic                 bus_ready,
  output logic                 bus_error,
  input  logic [NMASTER-1:0]   cfg_rd_allow,
  input  logic [NMASTER-1:0]   cfg_wr_allow,
  input  logic [FB_WS_W-1:0]   cfg_wait,
  input  logic [FB_WS_W-1:0]   cfg_xws_single,
  input  logic [FB_WS_W-1:0]   cfg_xws_burst,
  input  logic                 cfg_pipe,
  output logic                 arr_req,
  output logic                 arr_we,
  output logic [FB_ADDR_W-1:0] arr_addr,
  output logic [FB_DATA_W-1:0] arr_wdata,
  input  logic [FB_LINE_W-1:0] arr_rdata,
  input  logic                 arr_err
);
  logic  rd_ok, wr_ok, lk_hit, upd_en, upd_err, inv_en;
  line_t lk_line;
  tag_t  upd_tag, inv_tag;

  fbiu_perm_check #(.MID_W(MID_W)) u_perm (
    .mid(bus_mid), .rd_allow(cfg_rd_allow), .wr_allow(cfg_wr_allow),
    .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  fbiu_line_buf #(.NBUF(NBUF)) u_lbuf (
    .clk(clk), .rst_n(rst_n), .lk_tag(line_tag(bus_addr)), .lk_hit(lk_hit), .lk_line(lk_line),
    .upd_en(upd_en), .upd_err(upd_err), .upd_tag(upd_tag), .upd_line(arr_rdata),
    .inv_en(inv_en), .inv_tag(inv_tag)
  );

  fbiu_access_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .req_rd(bus_rd), .req_wr(bus_wr), .req_burst(bus_burst),
    .req_addr(bus_addr), .req_wdata(bus_wdata), .rd_ok(rd_ok), .wr_ok(wr_ok),
    .hit(lk_hit), .hit_line(lk_line), .cfg_wait(cfg_wait), .cfg_xs(cfg_xws_single),
    .cfg_xb(cfg_xws_burst), .cfg_pipe(cfg_pipe), .arr_req(arr_req), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .arr_err(arr_err),
    .resp_rdy(bus_ready), .resp_err(bus_error), .resp_data(bus_rdata),
    .upd_en(upd_en), .upd_err(upd_err), .upd_tag(upd_tag), .inv_en(inv_en), .inv_tag(inv_tag)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!bus_ready && !bus_error));
endmodule

// File: tb/test_flash_rdbuf_biu.sv
module test_flash_rdbuf_biu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rd = 0, bus_wr = 0, bus_burst = 0;
  logic [2:0] bus_mid = '0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_ready, bus_error;
  logic [7:0] cfg_rd_allow = 8'hFF, cfg_wr_allow = 8'hFF;
  logic [3:0] cfg_wait = 4'd2, cfg_xws_single = 4'd1, cfg_xws_burst = 4'd3;
  logic cfg_pipe = 1'b1;
  logic arr_req, arr_we;
  logic [31:0] arr_addr, arr_wdata;
  logic [127:0] arr_rdata;
  logic arr_err;

  int checks = 0, errors = 0;
  int req_cnt = 0;
  logic [31:0] stub_addr = '0;
  logic inj_err = 1'b0;

  logic [27:0] m_tag [4];
  bit          m_val [4];
  int          m_stamp [4];
  int          fill_no = 0;

  always #5 clk = ~clk;

  flash_rdbuf_biu i_flash_rdbuf_biu (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_burst(bus_burst),
    .bus_mid(bus_mid), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_error(bus_error), .cfg_rd_allow(cfg_rd_allow),
    .cfg_wr_allow(cfg_wr_allow), .cfg_wait(cfg_wait), .cfg_xws_single(cfg_xws_single),
    .cfg_xws_burst(cfg_xws_burst), .cfg_pipe(cfg_pipe), .arr_req(arr_req), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .arr_err(arr_err)
  );

  // Flash stub: contents are a function of the address; error is injected per transfer.
  function automatic logic [31:0] word_val(logic [27:0] t, int k);
    return (32'(t) * 32'h0001_9E37) ^ (32'(k) << 28) ^ 32'h5A5A_0F0F;
  endfunction

  always @(posedge clk) if (arr_req) begin
    stub_addr <= arr_addr;
    req_cnt   <= req_cnt + 1;
  end
  always_comb begin
    for (int k = 0; k < 4; k++) arr_rdata[k*32 +: 32] = word_val(stub_addr[31:4], k);
  end
  assign arr_err = inj_err;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int model_find(logic [27:0] t);
    for (int i = 0; i < 4; i++) if (m_val[i] && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic int model_victim();
    int v = 0;
    for (int i = 0; i < 4; i++) if (!m_val[i]) return i;
    for (int i = 1; i < 4; i++) if (m_stamp[i] < m_stamp[v]) v = i;
    return v;
  endfunction

  task automatic xfer(input bit rd, input bit burst, input logic [2:0] mid, input logic [31:0] addr,
                      input logic [31:0] wd, input bit err_inj, input bit drop_early, input string req);
    bit deny, hit, exp_arr, exp_err, pres_req;
    int w, exp_lat, lat, start_cnt, v;
    logic [31:0] exp_data;
    deny     = rd ? !cfg_rd_allow[mid] : !cfg_wr_allow[mid];
    hit      = rd && (model_find(addr[31:4]) >= 0);
    w        = int'(cfg_wait) + (rd ? int'(burst ? cfg_xws_burst : cfg_xws_single) : 0);
    exp_arr  = !deny && !hit;
    exp_lat  = (deny || hit) ? 1 : (cfg_pipe ? w + 2 : w + 3);
    exp_err  = deny || (exp_arr && err_inj);
    exp_data = word_val(addr[31:4], int'(addr[3:2]));

    @(negedge clk);
    inj_err = err_inj; bus_rd = rd; bus_wr = !rd; bus_burst = burst;
    bus_mid = mid; bus_addr = addr; bus_wdata = wd;
    start_cnt = req_cnt;
    #1 pres_req = arr_req;
    // R5: early request only with pipelining and an access to make
    chk(pres_req == (exp_arr && cfg_pipe), req, "R5 arr_req in presentation cycle", pres_req, exp_arr && cfg_pipe);
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (drop_early && lat == 1) begin bus_rd = 0; bus_wr = 0; end
      if (bus_ready || bus_error || lat > 100) break;
    end
    bus_rd = 0; bus_wr = 0; inj_err = 0;
    chk(lat == exp_lat, req, "response latency", lat, exp_lat);
    chk(bus_error == exp_err && bus_ready == !exp_err, req, "R11 response kind", {bus_ready, bus_error}, {!exp_err, exp_err});
    if (rd && !exp_err) chk(bus_rdata == exp_data, req, "R6 read data", bus_rdata, exp_data);
    chk((req_cnt - start_cnt) == int'(exp_arr), req, "R4 array request count", req_cnt - start_cnt, exp_arr);
    @(negedge clk);
    chk(!bus_ready && !bus_error, req, "R11 single-cycle response", {bus_ready, bus_error}, 0);

    if (!deny) begin
      if (rd && !hit) begin
        v = model_victim();
        if (err_inj) m_val[v] = 0;
        else begin m_val[v] = 1; m_tag[v] = addr[31:4]; m_stamp[v] = ++fill_no; end
      end
      if (!rd) begin
        v = model_find(addr[31:4]);
        if (v >= 0) m_val[v] = 0;
      end
    end
  endtask

  function automatic logic [31:0] ln(int n, int k);
    return 32'h0004_0000 + 32'(n) * 32'h10 + 32'(k) * 4;
  endfunction

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7321);
    for (int i = 0; i < 4; i++) begin m_val[i] = 0; m_tag[i] = '0; m_stamp[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet outputs after reset
    chk(!bus_ready && !bus_error && !arr_req, "R1", "idle outputs after reset",
        {bus_ready, bus_error, arr_req}, 0);

    xfer(1, 0, 3'd0, ln(1, 0), 0, 0, 0, "R1");       // first read misses
    xfer(1, 0, 3'd1, ln(1, 2), 0, 0, 0, "R3");       // hit on the same line
    xfer(1, 0, 3'd0, ln(2, 1), 0, 0, 0, "R7");
    xfer(1, 0, 3'd0, ln(3, 3), 0, 0, 0, "R7");
    xfer(1, 0, 3'd0, ln(4, 0), 0, 0, 0, "R7");
    xfer(1, 0, 3'd0, ln(1, 1), 0, 0, 0, "R7");       // hit does not refresh
    xfer(1, 0, 3'd0, ln(5, 0), 0, 0, 0, "R7");       // evicts line 1
    xfer(1, 0, 3'd0, ln(3, 0), 0, 0, 0, "R7");       // still held
    xfer(1, 0, 3'd0, ln(1, 3), 0, 0, 0, "R7");       // misses, evicts line 2
    xfer(1, 1, 3'd2, ln(6, 2), 0, 0, 0, "R4");       // burst extra wait
    cfg_pipe = 0;
    xfer(1, 0, 3'd2, ln(7, 1), 0, 0, 0, "R4");
    xfer(0, 0, 3'd2, ln(8, 0), 32'hDEAD_BEEF, 0, 0, "R4");
    cfg_pipe = 1;
    xfer(1, 0, 3'd3, ln(9, 0), 0, 1, 0, "R9");       // error, victim emptied
    xfer(1, 0, 3'd3, ln(9, 0), 0, 0, 0, "R9");
    xfer(1, 0, 3'd3, ln(9, 2), 0, 0, 0, "R9");
    xfer(0, 0, 3'd4, ln(9, 1), 32'h1234, 0, 0, "R10"); // write invalidates
    xfer(1, 0, 3'd4, ln(9, 1), 0, 0, 0, "R10");
    xfer(0, 0, 3'd4, ln(10, 0), 32'h55, 1, 0, "R10"); // write error
    cfg_rd_allow = 8'hDF; cfg_wr_allow = 8'hBF;
    xfer(1, 0, 3'd5, ln(11, 0), 0, 0, 0, "R2");
    xfer(1, 0, 3'd5, ln(9, 1), 0, 0, 0, "R2");        // even a held line is refused
    xfer(0, 0, 3'd6, ln(9, 1), 32'h77, 0, 0, "R2");
    xfer(1, 0, 3'd6, ln(9, 1), 0, 0, 0, "R2");        // refused write left line held
    cfg_rd_allow = 8'hFF; cfg_wr_allow = 8'hFF;
    cfg_wait = 4'd5;
    xfer(1, 0, 3'd1, ln(12, 2), 0, 0, 1, "R8");
    cfg_pipe = 0;
    xfer(0, 0, 3'd1, ln(13, 2), 32'h9, 0, 1, "R8");

    for (int n = 0; n < 400; n++) begin
      bit rd;
      if (n % 25 == 0) begin
        cfg_pipe       = 1'($urandom);
        cfg_wait       = 4'($urandom % 4);
        cfg_xws_single = 4'($urandom % 3);
        cfg_xws_burst  = 4'($urandom % 4);
        cfg_rd_allow   = 8'hFF & ~(8'h1 << ($urandom % 8));
        cfg_wr_allow   = 8'hFF & ~(8'h1 << ($urandom % 8));
      end
      rd = ($urandom % 5) != 0;
      xfer(rd, 1'($urandom), 3'($urandom), ln(20 + int'($urandom % 6), int'($urandom % 4)),
           $urandom, ($urandom % 10) == 0, 0, rd ? "R6" : "R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule